// File: doc/BRIEF.md
# FM Chip Probe and Init Sequencer

This block is a host-side bus master that brings up an FM-synthesis sound chip reached through an indexed register port. Each register write is done in two steps. The register index goes to the base address of a port pair. The value then goes to base plus one. Bit 8 of the nine-bit register index picks the primary or the secondary port pair. The sequencer runs once after every reset and needs no other prompting.

The run first checks whether a chip is present, using the chip's own interval timer. Both timers are masked and the interrupt flag is cleared, and a status byte is read. Then timer 1 is loaded and started, the block waits past its expiry, and status is read again. The two status bytes decide whether a chip is present. The first byte also sorts the chip into one of two kinds: two-operator or four-operator. A detected chip then gets a short initialisation list. While probing, each bus phase is followed by a fixed wait in clock cycles. During initialisation a faster chip, or an asserted force input, switches pacing to pairs of dummy status reads.

At the end the block pulses `done` for one cycle and holds `present` and `chip_four_op` until the next reset.

Top module: `fmprobe_seq`

## Requirements
- R1: Register write framing. A write puts index bits 7:0 at the base address, then puts the value at base+1. The base is `PRI_BASE` when index bit 8 is 0 and `SEC_BASE` when it is 1.
- R2: Bus handshake. At most one transfer is outstanding at a time. `bus_req` and its fields stay steady until `bus_ack` is seen, and `bus_req` is low in the cycle after the acknowledge.
- R3: Slow pacing. The next request waits at least IDX_US microseconds after an index phase is acknowledged, and at least DAT_US microseconds after a data phase.
- R4: Fast pacing. Exactly DUMMY_READS (2) reads of `PRI_BASE` follow each index phase and each data phase, with no fixed wait.
- R5: Probe start. The first three transfers are: write 0x60 to register 0x04 (both timers masked), write 0x80 to 0x04 (interrupt reset), then read status. If status bits 7:5 are not 000, the run ends with the chip absent and no further bus traffic.
- R6: Timer run. Next come: write 0xFF to register 0x02, write 0x21 to 0x04 (timer 2 masked, timer 1 started). The second status read then waits at least EXPIRE_US microseconds after that data phase.
- R7: After the second status read, 0x60 and then 0x80 are always written to register 0x04. The chip is absent unless bits 7:5 of the second status are 110. The lower bits are ignored.
- R8: Classification. A first status byte of exactly 0x06 means two-operator. Any other passing value means four-operator, and a four-operator chip counts as absent unless `secondary_cfg` is high. `chip_four_op` is high only when `present` is high.
- R9: Initialisation. Write 0x20 to register 0x01, then 0x00 to 0xBD. A four-operator chip also gets 0x01 written to register 0x105 (secondary bank).
- R10: Pacing choice. The probe always uses slow pacing. Initialisation uses fast pacing when the chip is four-operator or `force_fast` is high.
- R11: During reset all outputs are low. `done` pulses for exactly one cycle per reset. From that cycle on, `present` and `chip_four_op` hold their values and no further requests are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset; a run starts when it is released |
| secondary_cfg | input | 1 | High when the secondary port pair is wired up |
| force_fast | input | 1 | Forces fast pacing during initialisation |
| bus_req | output | 1 | Transfer request, held until acknowledged |
| bus_wr | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Port address of the transfer |
| bus_wdata | output | 8 | Write byte |
| bus_ack | input | 1 | One-cycle acknowledge from the chip side |
| bus_rdata | input | 8 | Read byte, valid in the acknowledge cycle |
| done | output | 1 | One-cycle pulse at the end of the run |
| present | output | 1 | A chip passed the probe |
| chip_four_op | output | 1 | The detected chip is four-operator |

## Verification
The checker relies on three things about the inputs. `secondary_cfg` and `force_fast` stay constant for a whole run. `bus_ack` only rises while a request is pending, for one cycle at a time. `bus_rdata` is valid in that same cycle. The bench changes the two configuration inputs only while reset is held. Its chip model acknowledges each request exactly once, after a latency of zero to two cycles set per run. It returns scripted status bytes for the first and second reads and a neutral value for every dummy read.

// File: rtl/fmp_pkg.sv
package fmp_pkg;

   // kinds of script step
   typedef enum logic [1:0] {
      K_WRITE = 2'd0,
      K_READ  = 2'd1,
      K_WAIT  = 2'd2,
      K_END   = 2'd3
   } step_kind_e;

   typedef struct packed {
      step_kind_e  kind;
      logic [8:0]  idx;
      logic [7:0]  val;
   } step_t;

   // register indices (bit 8 = secondary bank)
   localparam logic [8:0] RG_TEST  = 9'h001;
   localparam logic [8:0] RG_TMR1  = 9'h002;
   localparam logic [8:0] RG_TCTL  = 9'h004;
   localparam logic [8:0] RG_PERC  = 9'h0BD;
   localparam logic [8:0] RG_MODE  = 9'h105;

   // timer control bits
   localparam logic [7:0] TC_IRQ_CLR = 8'h80;
   localparam logic [7:0] TC_T1_MSK  = 8'h40;
   localparam logic [7:0] TC_T2_MSK  = 8'h20;
   localparam logic [7:0] TC_T1_RUN  = 8'h01;

   localparam logic [7:0] WAVE_EN    = 8'h20;
   localparam logic [7:0] MODE_EN    = 8'h01;
   localparam logic [7:0] SIG_TWO_OP = 8'h06;

   // script positions the sequencer decides on
   localparam logic [3:0] STP_STATUS1  = 4'd2;
   localparam logic [3:0] STP_STATUS2  = 4'd6;
   localparam logic [3:0] STP_CHECK2   = 4'd8;
   localparam logic [3:0] STP_INIT_1ST = 4'd9;
   localparam logic [3:0] STP_INIT_END = 4'd10;
   localparam logic [3:0] STP_MODE     = 4'd11;

   function automatic step_t script_step(input logic [3:0] n);
      step_t s;
      s = '{kind: K_END, idx: 9'h000, val: 8'h00};
      case (n)
         4'd0:  s = '{kind: K_WRITE, idx: RG_TCTL, val: TC_T1_MSK | TC_T2_MSK};
         4'd1:  s = '{kind: K_WRITE, idx: RG_TCTL, val: TC_IRQ_CLR};
         4'd2:  s = '{kind: K_READ,  idx: 9'h000,  val: 8'h00};
         4'd3:  s = '{kind: K_WRITE, idx: RG_TMR1, val: 8'hFF};
         4'd4:  s = '{kind: K_WRITE, idx: RG_TCTL, val: TC_T2_MSK | TC_T1_RUN};
         4'd5:  s = '{kind: K_WAIT,  idx: 9'h000,  val: 8'h00};
         4'd6:  s = '{kind: K_READ,  idx: 9'h000,  val: 8'h00};
         4'd7:  s = '{kind: K_WRITE, idx: RG_TCTL, val: TC_T1_MSK | TC_T2_MSK};
         4'd8:  s = '{kind: K_WRITE, idx: RG_TCTL, val: TC_IRQ_CLR};
         4'd9:  s = '{kind: K_WRITE, idx: RG_TEST, val: WAVE_EN};
         4'd10: s = '{kind: K_WRITE, idx: RG_PERC, val: 8'h00};
         4'd11: s = '{kind: K_WRITE, idx: RG_MODE, val: MODE_EN};
         default: s = '{kind: K_END, idx: 9'h000, val: 8'h00};
      endcase
      return s;
   endfunction

endpackage

// File: rtl/fmp_pacer.sv
module fmp_pacer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

endmodule

// File: rtl/fmp_bus_port.sv
module fmp_bus_port #(
   parameter int ADDR_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              st_wr,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic [7:0]        st_wdata,
   output logic              xfer_done,
   output logic [7:0]        rdata_q,
   output logic              bus_req,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rdata
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_req   <= 1'b0;
         bus_wr    <= 1'b0;
         bus_addr  <= '0;
         bus_wdata <= '0;
         xfer_done <= 1'b0;
         rdata_q   <= '0;
      end else begin
         xfer_done <= 1'b0;
         if (bus_req) begin
            if (bus_ack) begin
               bus_req   <= 1'b0;
               xfer_done <= 1'b1;
               rdata_q   <= bus_rdata;
            end
         end else if (start) begin
            bus_req   <= 1'b1;
            bus_wr    <= st_wr;
            bus_addr  <= st_addr;
            bus_wdata <= st_wdata;
         end
      end
   end

endmodule

// File: rtl/fmp_xfer_engine.sv
module fmp_xfer_engine
   import fmp_pkg::*;
#(
   parameter int              ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] PRI_BASE  = 16'h0100,
   parameter logic [ADDR_W-1:0] SEC_BASE  = 16'h0200,
   parameter int              CNT_W       = 8,
   parameter int              IDX_CYC     = 10,
   parameter int              DAT_CYC     = 30,
   parameter int              WAIT_CYC    = 200,
   parameter int              DUMMY_READS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  step_t             step_in,
   input  logic              fast_in,
   output logic              step_done,
   output logic [7:0]        rd_value,
   output logic              bus_req,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rdata
);

   localparam int DCNT_W = (DUMMY_READS > 1) ? $clog2(DUMMY_READS) : 1;
   localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(DUMMY_READS - 1);
   localparam logic [ADDR_W-1:0] PRI_DAT = PRI_BASE + 1'b1;
   localparam logic [ADDR_W-1:0] SEC_DAT = SEC_BASE + 1'b1;

   typedef enum logic [2:0] {
      E_IDLE, E_IDX, E_IDX_PACE, E_DAT, E_DAT_PACE, E_READ, E_WAIT
   } eng_st_e;

   eng_st_e           st, st_n;
   logic              launch, launch_n;
   logic [DCNT_W-1:0] dcnt, dcnt_n;
   step_t             cur, cur_n;
   logic              fast_q, fast_n;
   logic              done_n;
   logic [7:0]        rd_n;

   logic              pace_load;
   logic [CNT_W-1:0]  pace_val;
   logic              pace_zero;

   logic              xs, x_wr;
   logic [ADDR_W-1:0] x_addr;
   logic [7:0]        x_wdata;
   logic              bp_done;
   logic [7:0]        bp_rdata;

   always_comb begin
      st_n      = st;
      launch_n  = launch;
      dcnt_n    = dcnt;
      cur_n     = cur;
      fast_n    = fast_q;
      done_n    = 1'b0;
      rd_n      = rd_value;
      pace_load = 1'b0;
      pace_val  = '0;
      xs        = 1'b0;
      x_wr      = 1'b0;
      x_addr    = PRI_BASE;
      x_wdata   = 8'h00;
      case (st)
         E_IDLE: begin
            if (start) begin
               cur_n  = step_in;
               fast_n = fast_in;
               dcnt_n = '0;
               case (step_in.kind)
                  K_WRITE: begin st_n = E_IDX;  launch_n = 1'b1; end
                  K_READ:  begin st_n = E_READ; launch_n = 1'b1; end
                  K_WAIT:  begin
                     st_n      = E_WAIT;
                     pace_load = 1'b1;
                     pace_val  = CNT_W'(WAIT_CYC);
                  end
                  default: done_n = 1'b1;
               endcase
            end
         end
         E_IDX, E_DAT: begin
            x_wr    = 1'b1;
            x_addr  = (st == E_IDX) ? (cur.idx[8] ? SEC_BASE : PRI_BASE)
                                    : (cur.idx[8] ? SEC_DAT  : PRI_DAT);
            x_wdata = (st == E_IDX) ? cur.idx[7:0] : cur.val;
            xs      = launch;
            if (launch) launch_n = 1'b0;
            if (bp_done) begin
               st_n   = (st == E_IDX) ? E_IDX_PACE : E_DAT_PACE;
               dcnt_n = '0;
               if (fast_q) begin
                  launch_n = 1'b1;
               end else begin
                  pace_load = 1'b1;
                  pace_val  = (st == E_IDX) ? CNT_W'(IDX_CYC) : CNT_W'(DAT_CYC);
               end
            end
         end
         E_IDX_PACE, E_DAT_PACE: begin
            if (fast_q) begin
               xs = launch;
               if (launch) launch_n = 1'b0;
               if (bp_done) begin
                  if (dcnt == DCNT_LAST) begin
                     if (st == E_IDX_PACE) begin
                        st_n = E_DAT; launch_n = 1'b1;
                     end else begin
                        st_n = E_IDLE; done_n = 1'b1;
                     end
                  end else begin
                     dcnt_n   = dcnt + 1'b1;
                     launch_n = 1'b1;
                  end
               end
            end else if (pace_zero) begin
               if (st == E_IDX_PACE) begin
                  st_n = E_DAT; launch_n = 1'b1;
               end else begin
                  st_n = E_IDLE; done_n = 1'b1;
               end
            end
         end
         E_READ: begin
            xs = launch;
            if (launch) launch_n = 1'b0;
            if (bp_done) begin
               rd_n   = bp_rdata;
               done_n = 1'b1;
               st_n   = E_IDLE;
            end
         end
         E_WAIT: begin
            if (pace_zero) begin
               done_n = 1'b1;
               st_n   = E_IDLE;
            end
         end
         default: st_n = E_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= E_IDLE;
         launch    <= 1'b0;
         dcnt      <= '0;
         cur       <= '{kind: K_END, idx: 9'h000, val: 8'h00};
         fast_q    <= 1'b0;
         step_done <= 1'b0;
         rd_value  <= 8'h00;
      end else begin
         st        <= st_n;
         launch    <= launch_n;
         dcnt      <= dcnt_n;
         cur       <= cur_n;
         fast_q    <= fast_n;
         step_done <= done_n;
         rd_value  <= rd_n;
      end
   end

   fmp_pacer #(.CNT_W(CNT_W)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (pace_load),
      .load_val (pace_val),
      .zero     (pace_zero)
   );

   fmp_bus_port #(.ADDR_W(ADDR_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (xs),
      .st_wr     (x_wr),
      .st_addr   (x_addr),
      .st_wdata  (x_wdata),
      .xfer_done (bp_done),
      .rdata_q   (bp_rdata),
      .bus_req   (bus_req),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );

endmodule

// File: rtl/fmprobe_seq.sv
module fmprobe_seq
   import fmp_pkg::*;
#(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] PRI_BASE    = 16'h0100,
   parameter logic [ADDR_W-1:0] SEC_BASE    = 16'h0200,
   parameter int unsigned       CLK_HZ      = 100_000_000,
   parameter int                IDX_US      = 10,
   parameter int                DAT_US      = 30,
   parameter int                EXPIRE_US   = 200,
   parameter int                DUMMY_READS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              secondary_cfg,
   input  logic              force_fast,
   output logic              bus_req,
   output logic              bus_wr,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_wdata,
   input  logic              bus_ack,
   input  logic [7:0]        bus_rdata,
   output logic              done,
   output logic              present,
   output logic              chip_four_op
);

   localparam int CLK_MHZ  = int'((CLK_HZ + 32'd999_999) / 32'd1_000_000);
   localparam int IDX_CYC  = CLK_MHZ * IDX_US;
   localparam int DAT_CYC  = CLK_MHZ * DAT_US;
   localparam int WAIT_CYC = CLK_MHZ * EXPIRE_US;
   localparam int MAX_A    = (IDX_CYC > DAT_CYC) ? IDX_CYC : DAT_CYC;
   localparam int MAX_CYC  = (MAX_A > WAIT_CYC) ? MAX_A : WAIT_CYC;
   localparam int CNT_W    = $clog2(MAX_CYC + 1);

   // elaboration checks on the parameter set
   if (CLK_HZ < 32'd1_000_000) begin : g_bad_clk
      $error("fmprobe_seq: CLK_HZ must be at least 1 MHz");
   end
   if (IDX_US < 1 || DAT_US < 1 || EXPIRE_US < 1) begin : g_bad_delay
      $error("fmprobe_seq: every delay must be at least 1 us");
   end
   if (DUMMY_READS < 1) begin : g_bad_dummy
      $error("fmprobe_seq: DUMMY_READS must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("fmprobe_seq: ADDR_W too narrow");
   end
   if ((PRI_BASE == SEC_BASE) || (PRI_BASE + 1'b1 == SEC_BASE) ||
       (SEC_BASE + 1'b1 == PRI_BASE)) begin : g_bad_bases
      $error("fmprobe_seq: port pairs overlap");
   end

   typedef enum logic [1:0] {T_ISSUE, T_WAIT, T_HALT} top_st_e;

   top_st_e    st;
   logic [3:0] step_no;
   logic [7:0] s1_q;
   logic [2:0] s2_top;
   logic       four_q;
   logic       eng_start;
   logic       eng_done;
   logic [7:0] eng_rd;
   step_t      cur_step;
   logic       fast_now;

   assign cur_step  = script_step(step_no);
   assign eng_start = (st == T_ISSUE);
   assign fast_now  = (step_no >= STP_INIT_1ST) && (four_q || force_fast);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st           <= T_ISSUE;
         step_no      <= 4'd0;
         s1_q         <= 8'h00;
         s2_top       <= 3'b000;
         four_q       <= 1'b0;
         done         <= 1'b0;
         present      <= 1'b0;
         chip_four_op <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            T_ISSUE: st <= T_WAIT;
            T_WAIT: begin
               if (eng_done) begin
                  st      <= T_ISSUE;
                  step_no <= step_no + 4'd1;
                  case (step_no)
                     STP_STATUS1: begin
                        s1_q <= eng_rd;
                        if (eng_rd[7:5] != 3'b000) begin
                           st   <= T_HALT;
                           done <= 1'b1;
                        end
                     end
                     STP_STATUS2: s2_top <= eng_rd[7:5];
                     STP_CHECK2: begin
                        if (s2_top != 3'b110) begin
                           st   <= T_HALT;
                           done <= 1'b1;
                        end else if ((s1_q != SIG_TWO_OP) && !secondary_cfg) begin
                           st   <= T_HALT;
                           done <= 1'b1;
                        end else begin
                           four_q <= (s1_q != SIG_TWO_OP);
                        end
                     end
                     STP_INIT_END: begin
                        if (!four_q) begin
                           st      <= T_HALT;
                           done    <= 1'b1;
                           present <= 1'b1;
                        end
                     end
                     STP_MODE: begin
                        st           <= T_HALT;
                        done         <= 1'b1;
                        present      <= 1'b1;
                        chip_four_op <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            default: st <= T_HALT;
         endcase
      end
   end

   fmp_xfer_engine #(
      .ADDR_W      (ADDR_W),
      .PRI_BASE    (PRI_BASE),
      .SEC_BASE    (SEC_BASE),
      .CNT_W       (CNT_W),
      .IDX_CYC     (IDX_CYC),
      .DAT_CYC     (DAT_CYC),
      .WAIT_CYC    (WAIT_CYC),
      .DUMMY_READS (DUMMY_READS)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (eng_start),
      .step_in   (cur_step),
      .fast_in   (fast_now),
      .step_done (eng_done),
      .rd_value  (eng_rd),
      .bus_req   (bus_req),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_ack   (bus_ack),
      .bus_rdata (bus_rdata)
   );

endmodule

// File: rtl/fmprobe_seq_chk.sv
module fmprobe_seq_chk #(
   parameter int                ADDR_W   = 16,
   parameter logic [ADDR_W-1:0] PRI_BASE = 16'h0100,
   parameter logic [ADDR_W-1:0] SEC_BASE = 16'h0200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              secondary_cfg,
   input logic              bus_req,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              bus_ack,
   input logic              done,
   input logic              present,
   input logic              chip_four_op
);

   localparam logic [ADDR_W-1:0] PRI_DAT = PRI_BASE + 1'b1;
   localparam logic [ADDR_W-1:0] SEC_DAT = SEC_BASE + 1'b1;

   logic done_seen;
   always_ff @(posedge clk) begin
      if (!rst_n) done_seen <= 1'b0;
      else if (done) done_seen <= 1'b1;
   end

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req);                                   // R2
   AST_FIELDS_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> $stable(bus_wr) && $stable(bus_addr) && $stable(bus_wdata)); // R2
   AST_REQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> !bus_req);                                   // R2
   AST_ADDR_IN_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_addr == PRI_BASE || bus_addr == PRI_DAT ||
                   bus_addr == SEC_BASE || bus_addr == SEC_DAT));         // R1
   AST_READ_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_wr |-> bus_addr == PRI_BASE);                       // R4
   AST_SEC_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && (bus_addr == SEC_BASE || bus_addr == SEC_DAT) |-> secondary_cfg); // R8
   AST_FOUR_IMPLIES_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
      chip_four_op |-> present);                                          // R8
   AST_DONE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      done_seen |-> !done);                                               // R11
   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_seen |-> !bus_req);                                            // R11
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      done_seen |-> $stable(present) && $stable(chip_four_op));           // R11
   AST_NO_EARLY_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      !done_seen && !done |-> !present && !chip_four_op);                 // R11

endmodule

bind fmprobe_seq fmprobe_seq_chk #(
   .ADDR_W   (ADDR_W),
   .PRI_BASE (PRI_BASE),
   .SEC_BASE (SEC_BASE)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .secondary_cfg (secondary_cfg),
   .bus_req       (bus_req),
   .bus_wr        (bus_wr),
   .bus_addr      (bus_addr),
   .bus_wdata     (bus_wdata),
   .bus_ack       (bus_ack),
   .done          (done),
   .present       (present),
   .chip_four_op  (chip_four_op)
);

// File: tb/fmprobe_seq_bench.sv
module fmprobe_seq_bench;

   localparam int ADDR_W = 16;
   localparam logic [15:0] PRI = 16'h0100;
   localparam logic [15:0] SEC = 16'h0200;
   localparam int unsigned CLK_HZ = 1_000_000;  // one cycle per microsecond
   localparam int IDX_G = 10;
   localparam int DAT_G = 30;
   localparam int EXP_G = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        secondary_cfg = 1'b0;
   logic        force_fast = 1'b0;
   logic        bus_req, bus_wr;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata;
   logic        bus_ack = 1'b0;
   logic [7:0]  bus_rdata = 8'h00;
   logic        done, present, chip_four_op;

   always #5 clk = ~clk;

   fmprobe_seq #(
      .ADDR_W (ADDR_W), .PRI_BASE (PRI), .SEC_BASE (SEC), .CLK_HZ (CLK_HZ),
      .IDX_US (IDX_G), .DAT_US (DAT_G), .EXPIRE_US (EXP_G), .DUMMY_READS (2)
   ) u_fmprobe_seq (
      .clk (clk), .rst_n (rst_n), .secondary_cfg (secondary_cfg),
      .force_fast (force_fast), .bus_req (bus_req), .bus_wr (bus_wr),
      .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ack (bus_ack),
      .bus_rdata (bus_rdata), .done (done), .present (present),
      .chip_four_op (chip_four_op)
   );

   typedef struct {
      bit    wr;
      int    addr;
      int    data;
      int    gap;
      string tag;
      string gtag;
   } txn_t;

   txn_t  exp_q[$];
   int    compared = 0;
   int    mismatched = 0;
   int    cyc = 0;
   int    pos = 0;
   int    n_reads = 0;
   int    done_cnt = 0;
   int    last_ack = 0;
   int    wcnt = 0;
   int    lat = 0;
   bit    active = 0;
   bit    finished = 0;
   logic [7:0] st1 = 8'h00;
   logic [7:0] st2 = 8'h00;
   int    next_gap = 0;
   string next_gtag = "R3";

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, expv, cyc);
      end
   endtask

   function automatic void push(input bit wr, input int addr, input int data,
                                input int gap, input string tag, input string gtag);
      txn_t t;
      t.wr = wr; t.addr = addr; t.data = data; t.gap = gap; t.tag = tag; t.gtag = gtag;
      exp_q.push_back(t);
   endfunction

   function automatic void add_dummies();
      push(1'b0, PRI, 0, 0, "R4", "R4");
      push(1'b0, PRI, 0, 0, "R4", "R4");
      next_gap = 0;
   endfunction

   function automatic void add_write(input int idx, input int val, input bit fast,
                                     input string tag);
      int base;
      base = idx[8] ? int'(SEC) : int'(PRI);
      push(1'b1, base, idx & 255, next_gap, tag, next_gtag);
      if (fast) add_dummies();
      else next_gap = IDX_G;
      next_gtag = "R3";
      push(1'b1, base + 1, val, next_gap, tag, next_gtag);
      if (fast) add_dummies();
      else next_gap = DAT_G;
   endfunction

   function automatic void add_read(input int min_gap, input string tag);
      if (min_gap > next_gap) begin
         push(1'b0, PRI, 0, min_gap, tag, "R6");
      end else begin
         push(1'b0, PRI, 0, next_gap, tag, "R3");
      end
      next_gap = 0;
   endfunction

   // expected transfer list and result, from the requirements
   task automatic build(input logic [7:0] s1, input logic [7:0] s2, input bit sec,
                        input bit frc, output bit e_pres, output bit e_four);
      bit four, fast;
      exp_q.delete();
      next_gap = 0;
      next_gtag = "R3";
      e_pres = 0; e_four = 0;
      add_write(4, 'h60, 0, "R1 R5");
      add_write(4, 'h80, 0, "R1 R5");
      add_read(0, "R5");
      if (s1[7:5] != 3'b000) return;
      add_write(2, 'hFF, 0, "R6");
      add_write(4, 'h21, 0, "R6");
      add_read(EXP_G, "R6");
      add_write(4, 'h60, 0, "R7");
      add_write(4, 'h80, 0, "R7");
      if (s2[7:5] != 3'b110) return;
      four = (s1 != 8'h06);
      if (four && !sec) return;
      fast = four || frc;
      add_write('h001, 'h20, fast, "R9");
      add_write('h0BD, 'h00, fast, "R9");
      if (four) add_write('h105, 'h01, fast, "R1 R9");
      e_pres = 1; e_four = four;
   endtask

   // chip model and per-clock comparison, all away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         if (!rst_n) begin
            bus_ack = 1'b0;
            wcnt = 0;
            active = 0;
            last_ack = cyc;
         end else begin
            if (done) done_cnt++;
            if (bus_ack) begin
               chk(bus_req == 1'b0, "R2", "request not released after ack", bus_req, 0);
               bus_ack = 1'b0;
            end else if (bus_req) begin
               if (pos < exp_q.size()) begin
                  chk(bus_wr == exp_q[pos].wr, exp_q[pos].tag, "direction", bus_wr, exp_q[pos].wr);
                  chk(bus_addr == exp_q[pos].addr[15:0], exp_q[pos].tag, "address",
                      bus_addr, exp_q[pos].addr);
                  if (exp_q[pos].wr)
                     chk(bus_wdata == exp_q[pos].data[7:0], exp_q[pos].tag, "write byte",
                         bus_wdata, exp_q[pos].data);
                  if (!active)
                     chk((cyc - last_ack) >= exp_q[pos].gap, exp_q[pos].gtag,
                         "pacing gap before request", cyc - last_ack, exp_q[pos].gap);
               end else if (!active) begin
                  chk(1'b0, "R10", "unexpected extra transfer at addr", bus_addr, 0);
               end
               active = 1;
               if (wcnt == lat) begin
                  bus_ack = 1'b1;
                  if (!bus_wr) begin
                     bus_rdata = (n_reads == 0) ? st1 : (n_reads == 1) ? st2 : 8'h5A;
                     n_reads++;
                  end
                  pos++;
                  last_ack = cyc;
                  active = 0;
                  wcnt = 0;
               end else begin
                  wcnt++;
               end
            end
         end
      end
   end

   task automatic run_case(input string name, input logic [7:0] s1, input logic [7:0] s2,
                           input bit sec, input bit frc, input int l);
      bit e_pres, e_four;
      int settle;
      rst_n = 1'b0;
      secondary_cfg = sec;
      force_fast = frc;
      st1 = s1; st2 = s2; lat = l;
      build(s1, s2, sec, frc, e_pres, e_four);
      repeat (3) @(negedge clk);
      pos = 0; n_reads = 0; done_cnt = 0;
      // R11 reset state
      chk(bus_req == 1'b0 && done == 1'b0 && present == 1'b0 && chip_four_op == 1'b0,
          "R11", {name, " outputs in reset"}, {bus_req, done, present, chip_four_op}, 0);
      rst_n = 1'b1;
      settle = 0;
      while (done_cnt == 0 && settle < 4000) begin
         @(negedge clk);
         settle++;
      end
      chk(done_cnt == 1, "R11", {name, " done pulse seen"}, done_cnt, 1);
      repeat (40) @(negedge clk);
      chk(done_cnt == 1, "R11", {name, " single done pulse"}, done_cnt, 1);
      chk(present == e_pres, "R8", {name, " present"}, present, e_pres);
      chk(chip_four_op == e_four, "R8", {name, " four-operator flag"}, chip_four_op, e_four);
      chk(pos == exp_q.size(), "R10", {name, " transfer count"}, pos, exp_q.size());
      chk(bus_req == 1'b0, "R11", {name, " idle after done"}, bus_req, 0);
   endtask

   initial begin
      run_case("two-op slow",       8'h06, 8'hC0, 1'b0, 1'b0, 0);  // R9 R10
      run_case("four-op fast",      8'h00, 8'hC0, 1'b1, 1'b0, 1);  // R1 R4 R9 R10
      run_case("four-op no sec",    8'h00, 8'hC0, 1'b0, 1'b0, 0);  // R8
      run_case("status1 bit7",      8'h80, 8'hC0, 1'b1, 1'b0, 2);  // R5
      run_case("status1 bit5",      8'h26, 8'hC0, 1'b1, 1'b0, 0);  // R5
      run_case("status2 wrong",     8'h06, 8'h40, 1'b1, 1'b0, 1);  // R7
      run_case("two-op forced fast",8'h06, 8'hDF, 1'b1, 1'b1, 2);  // R7 R10
      run_case("four-op low bits",  8'h1F, 8'hC3, 1'b1, 1'b1, 0);  // R8 R9
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      #(150000 * 10);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog expired: run did not complete (actual=1 expected=0)");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule